// File: doc/BRIEF.md
# Edge-triggered external interrupt controller

The block watches up to 32 external signal lines and turns selected transitions on them into interrupt requests. Every line first passes through a two-stage synchroniser. A rising transition, a falling transition, or either one can be set to latch a per-line pending flag. Software can also set that flag directly. The pending flags stay set until software clears them by writing ones. One interrupt output is the OR of all pending lines that are unmasked. A separate event output gives a single-cycle pulse whenever a selected transition occurs on a line that is enabled as a wakeup source.

Software reaches six 32-bit registers through a word-indexed write port and a combinational read port. The word index is the byte offset divided by four:

| Index | Register |
|-------|----------|
| 0 | interrupt enable |
| 1 | event enable |
| 2 | rising select |
| 3 | falling select |
| 4 | software set |
| 5 | pending |

Bits above the configured line count are constant zero. Software can therefore find the number of lines by writing all ones to a select register and reading back the position of the highest set bit.

Top module: `eic_top`

## Requirements
- R1: After reset, all six registers read 0 and both `irq_o` and `evt_o` are 0.
- R2: In every register, bits at positions NUM_LINES and above ignore writes and read as 0. Writing all ones to the rising select register (index 2) reads back as (1<<NUM_LINES)-1.
- R3: A line with rising select bit = 1 latches pending on a 0→1 transition. A line with falling select bit = 1 latches pending on a 1→0 transition. With both bits set, either transition latches pending. With neither set, no transition latches pending. Pending becomes visible on the third rising clock edge after the input changes.
- R4: Pending latches on a selected edge even when the line's interrupt enable bit (index 0) is 0.
- R5: Writing to pending (index 5) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: If a selected edge sets a pending bit in the same cycle that software writes 1 to clear it, the bit stays 1.
- R7: Writing 1 to a bit of the software set register (index 4) sets the matching pending bit. That bit then reads 1 until the pending bit is cleared. Writing 0 to the register changes nothing.
- R8: A selected edge on a line whose event enable bit (index 1) is 1 drives `evt_o` high for exactly one cycle. This happens in the same cycle that the pending bit becomes visible, whether or not pending was already set and whatever the interrupt enable. With the event enable bit at 0, no pulse occurs.
- R9: `irq_o` is 1 exactly when at least one line has both its pending bit and its interrupt enable bit at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | NUM_LINES | Raw external lines, asynchronous |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| idx_i | input | 3 | Register word index (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `idx_i`, combinational |
| irq_o | output | 1 | Combined interrupt request |
| evt_o | output | 1 | Combined event/wakeup pulse |

## Verification
A small six-line build is swept over every line and every polarity setting. At each step the bench checks the pending bit, the interrupt output and the event pulse. A design that swapped polarities, or that detected edges with one stage too few or too many, would latch the wrong line or miss the sampling cycle. The bench times a clearing write so that it lands in the same cycle as a new edge. A design that let the clear win would lose an interrupt that arrives while software is servicing. Further checks cover read-back of unimplemented bits, masked lines still latching pending, a write of zero to the software set or pending register, and the event pulse lasting only one cycle. Errors here would show up as a wrong line count, silently lost requests, or stuck or missing wakeups.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IDX_W  = 3;

  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [IDX_W-1:0] {
    IDX_IMASK  = 3'd0,
    IDX_EMASK  = 3'd1,
    IDX_RISE   = 3'd2,
    IDX_FALL   = 3'd3,
    IDX_SWSET  = 3'd4,
    IDX_PEND   = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/eic_edge_detect.sv
module eic_edge_detect #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  output logic [NUM_LINES-1:0] rise_o,
  output logic [NUM_LINES-1:0] fall_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= line_i[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign rise_o[g] = sync_q & ~prev_q;
    assign fall_o[g] = ~sync_q & prev_q;
  end

  // a synchronised level cannot toggle twice in back-to-back cycles
  assert_rise_isolated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o & $past(rise_o)) == '0);
  assert_fall_isolated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_o & $past(fall_o)) == '0);
endmodule

// File: rtl/eic_regfile.sv
module eic_regfile
  import eic_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  input  logic [NUM_LINES-1:0] rise_i,
  input  logic [NUM_LINES-1:0] fall_i,
  output logic [NUM_LINES-1:0] imask_o,
  output logic [NUM_LINES-1:0] emask_o,
  output logic [NUM_LINES-1:0] hit_o,
  output logic [NUM_LINES-1:0] pend_o,
  output word_t                rdata_o
);
  logic [NUM_LINES-1:0] imask_q, emask_q, rise_sel_q, fall_sel_q, swset_q, pend_q;
  logic [NUM_LINES-1:0] sw_set, clr_vec, set_vec, pend_d;

  assign hit_o   = (rise_i & rise_sel_q) | (fall_i & fall_sel_q);
  assign sw_set  = (wr_en_i && idx_i == IDX_SWSET) ? wdata_i : '0;
  assign clr_vec = (wr_en_i && idx_i == IDX_PEND)  ? wdata_i : '0;
  assign set_vec = hit_o | sw_set;
  // set dominates clear so an edge during servicing is never lost
  assign pend_d  = (pend_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imask_q    <= '0;
      emask_q    <= '0;
      rise_sel_q <= '0;
      fall_sel_q <= '0;
      swset_q    <= '0;
      pend_q     <= '0;
    end else begin
      if (wr_en_i) begin
        unique case (idx_i)
          IDX_IMASK: imask_q    <= wdata_i;
          IDX_EMASK: emask_q    <= wdata_i;
          IDX_RISE:  rise_sel_q <= wdata_i;
          IDX_FALL:  fall_sel_q <= wdata_i;
          default: ;
        endcase
      end
      pend_q  <= pend_d;
      swset_q <= (swset_q | sw_set) & pend_d;
    end
  end

  always_comb begin
    unique case (idx_i)
      IDX_IMASK: rdata_o = word_t'(imask_q);
      IDX_EMASK: rdata_o = word_t'(emask_q);
      IDX_RISE:  rdata_o = word_t'(rise_sel_q);
      IDX_FALL:  rdata_o = word_t'(fall_sel_q);
      IDX_SWSET: rdata_o = word_t'(swset_q);
      IDX_PEND:  rdata_o = word_t'(pend_q);
      default:   rdata_o = '0;
    endcase
  end

  assign imask_o = imask_q;
  assign emask_o = emask_q;
  assign pend_o  = pend_q;

  assert_edge_latches_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o != '0) |=> ((pend_q & $past(hit_o)) == $past(hit_o)));
  assert_w1c_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx_i == IDX_PEND) |=> ((pend_q & $past(wdata_i & ~hit_o)) == '0));
  assert_pend_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && idx_i == IDX_PEND) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  assert_swset_latches_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx_i == IDX_SWSET) |=> ((pend_q & $past(wdata_i)) == $past(wdata_i)));
endmodule

// File: rtl/eic_top.sv
module eic_top
  import eic_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 irq_o,
  output logic                 evt_o
);
  logic [NUM_LINES-1:0] rise, fall, imask, emask, hit, pend;
  logic                 evt_q;

  eic_edge_detect #(.NUM_LINES(NUM_LINES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  eic_regfile #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .idx_i   (idx_i),
    .wdata_i (wdata_i[NUM_LINES-1:0]),
    .rise_i  (rise),
    .fall_i  (fall),
    .imask_o (imask),
    .emask_o (emask),
    .hit_o   (hit),
    .pend_o  (pend),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= |(hit & emask);
  end

  assign evt_o = evt_q;
  assign irq_o = |(pend & imask);

  assert_irq_off_when_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imask == '0) |-> !irq_o);
  assert_evt_has_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (pend != '0));
  assert_unimpl_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o >> NUM_LINES) == '0);
endmodule

// File: tb/sim_eic_top.sv
module sim_eic_top;
  localparam int unsigned PERIOD = 10;
  localparam int unsigned N      = 6;
  localparam logic [31:0] ALL    = (32'd1 << N) - 32'd1;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] line = '0;
  logic         wr_en = 1'b0;
  logic [2:0]   idx = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         irq, evt;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  eic_top #(.NUM_LINES(N)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line), .wr_en_i(wr_en),
    .idx_i(idx), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .evt_o(evt)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; write lands on the following posedge
  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    wr_en = 1'b1; idx = i; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] i, input logic [31:0] exp);
    idx = i;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_neg(2);
    // R1 reset state
    for (int i = 0; i < 6; i++) rd_check("R1 reg reset", 3'(i), 32'd0);
    check("R1 irq reset", {31'd0, irq}, 32'd0);
    check("R1 evt reset", {31'd0, evt}, 32'd0);
    rst_ni = 1'b1;
    wait_neg(1);

    // R2 unimplemented bits
    for (int i = 0; i < 4; i++) begin
      wr(3'(i), 32'hFFFF_FFFF);
      rd_check("R2 readback mask", 3'(i), ALL);
      wr(3'(i), 32'd0);
    end
    wr(3'd4, 32'hFFFF_FFFF);
    rd_check("R2 swset upper", 3'd4, ALL);
    rd_check("R2 pend upper", 3'd5, ALL);
    wr(3'd5, 32'hFFFF_FFFF);
    rd_check("R2 pend cleared", 3'd5, 32'd0);
    rd_check("R2 unmapped index", 3'd7, 32'd0);

    // R3 / R8 / R9 sweep over every line and polarity mode
    for (int l = 0; l < N; l++) begin
      for (int m = 0; m < 4; m++) begin
        logic r, f;
        r = m[0]; f = m[1];
        wr(3'd2, r ? (32'd1 << l) : 32'd0);
        wr(3'd3, f ? (32'd1 << l) : 32'd0);
        wr(3'd0, ALL);
        wr(3'd1, 32'd1 << l);
        wr(3'd5, ALL);
        line[l] = 1'b1;
        wait_neg(2);
        check("R3 not yet latched", {31'd0, irq}, 32'd0);
        wait_neg(1);
        rd_check("R3 rise pending", 3'd5, r ? (32'd1 << l) : 32'd0);
        check("R9 irq rise", {31'd0, irq}, {31'd0, r});
        check("R8 evt rise", {31'd0, evt}, {31'd0, r});
        wait_neg(1);
        check("R8 evt one cycle", {31'd0, evt}, 32'd0);
        wr(3'd5, ALL);
        line[l] = 1'b0;
        wait_neg(3);
        rd_check("R3 fall pending", 3'd5, f ? (32'd1 << l) : 32'd0);
        check("R9 irq fall", {31'd0, irq}, {31'd0, f});
        check("R8 evt fall", {31'd0, evt}, {31'd0, f});
        wait_neg(1);
        wr(3'd5, ALL);
      end
    end

    // R4 masked line latches, irq follows enable
    wr(3'd0, 32'd0); wr(3'd1, 32'd0); wr(3'd3, 32'd0);
    wr(3'd2, 32'd1 << 2);
    line[2] = 1'b1;
    wait_neg(3);
    rd_check("R4 masked pending", 3'd5, 32'd4);
    check("R4 irq masked", {31'd0, irq}, 32'd0);
    check("R8 evt disabled", {31'd0, evt}, 32'd0);
    wr(3'd0, 32'd4);
    check("R9 irq after unmask", {31'd0, irq}, 32'd1);
    wr(3'd5, ALL);
    line[2] = 1'b0;
    wait_neg(3);

    // R5 / R7 w1c and software set
    wr(3'd0, 32'd0);
    wr(3'd4, 32'h2D);
    rd_check("R7 pend from swset", 3'd5, 32'h2D);
    rd_check("R7 swset readback", 3'd4, 32'h2D);
    wr(3'd4, 32'd0);
    rd_check("R7 zero write no effect", 3'd4, 32'h2D);
    wr(3'd5, 32'h05);
    rd_check("R5 partial clear", 3'd5, 32'h28);
    rd_check("R7 swset follows clear", 3'd4, 32'h28);
    wr(3'd5, 32'd0);
    rd_check("R5 zero write no effect", 3'd5, 32'h28);
    wr(3'd5, ALL);
    rd_check("R5 full clear", 3'd5, 32'd0);
    rd_check("R7 swset cleared", 3'd4, 32'd0);

    // R9 mixed masked / unmasked pending
    wr(3'd0, 32'h02);
    wr(3'd4, 32'h04);
    check("R9 masked only", {31'd0, irq}, 32'd0);
    wr(3'd4, 32'h02);
    check("R9 unmasked pending", {31'd0, irq}, 32'd1);
    wr(3'd5, 32'h02);
    check("R9 drop after clear", {31'd0, irq}, 32'd0);
    wr(3'd5, ALL);

    // R6 edge and clear in same cycle
    wr(3'd2, 32'h02);
    wr(3'd4, 32'h02);
    line[1] = 1'b1;
    wait_neg(2);
    wr(3'd5, 32'h02);
    rd_check("R6 set beats clear", 3'd5, 32'h02);
    wr(3'd5, 32'h02);
    rd_check("R6 later clear works", 3'd5, 32'd0);

    // R8 pulse even when pending already set, interrupt disabled
    wr(3'd0, 32'd0);
    wr(3'd1, 32'h02);
    wr(3'd3, 32'h02);
    wr(3'd4, 32'h02);
    line[1] = 1'b0;
    wait_neg(3);
    check("R8 evt with prior pending", {31'd0, evt}, 32'd1);
    check("R9 irq disabled", {31'd0, irq}, 32'd0);
    wait_neg(1);
    check("R8 evt ends", {31'd0, evt}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule